// File: doc/BRIEF.md
# Distinct-Bias Oscillator Assignment Search

This block chooses a bias level for each of three free-running noise oscillators, each of which offers four bias levels. Software or a measurement engine first fills a 3x4 table of unsigned 64-bit entropy scores through a simple write port, one score per oscillator/bias pair. A start strobe then launches an exhaustive search. The search considers only assignments in which all three oscillators sit at different bias levels, because two oscillators at the same level tend to lock together. It keeps the assignment with the largest summed score.

When the search completes, the block raises `done` and presents five results. The first is the winning assignment as a packed bias word. The second is the three scores of the winning cells. The third is the winning total. The fourth is a pass flag that compares the total against a fixed entropy floor. The last is a set of four control words ready to program the oscillator bank: one per oscillator, plus a final word that enables all three. The search walks one index code per clock and takes a fixed number of cycles. The score table is frozen while the search is running.

Top module: `bias_assign_search`

## Requirements
- R1: Only assignments whose three biases are pairwise different can win. The packed bias word carries oscillator n's bias in bits [2n+1:2n].
- R2: The search visits candidates with oscillator 0's bias as the slowest-changing digit and oscillator 2's bias as the fastest, each counting up from 0. A candidate replaces the held best only when its total is strictly greater, so on a tie the earlier candidate is kept.
- R3: The held best total starts at 0 and the held assignment starts as oscillator n at bias n. If no candidate total exceeds 0, that default assignment is kept.
- R4: `pass` is 1 only while `done` is 1 and the best total is at least 150000000. While `pass` is 0, `bias_word` and `cell_score` read as zero. `best_total` is always shown unmasked.
- R5: Control word n (n = 0..2) occupies `ctl_words[6n+5:6n]`. Its layout is: select in bits [2:0] = 1 shifted left by n, the chosen bias of oscillator n in bits [4:3], and the normal-mode bit [5] = 1. This holds whether or not `pass` is set.
- R6: Control word 3 (`ctl_words[23:18]`) has select 3'b111, bias 0 and mode 1.
- R7: A start accepted at clock edge k raises `done` at edge k+64 and clears `done` at edge k. A start while the search is running is ignored. The results hold until the next accepted start.
- R8: A table write stores `tbl_wr_score` at (`tbl_wr_osc`, `tbl_wr_bias`). A write in the same cycle as an accepted start is used by that search. A write while the search is running is dropped.
- R9: Totals are formed without overflow, even with every score at 2^64-1. `best_total` is 66 bits wide and `cell_score[64n+63:64n]` is oscillator n's winning score.
- R10: After reset, `done`=0, `pass`=0, `best_total`=0, and the score table is all zero. The control words reflect the default assignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Score table write strobe |
| tbl_wr_osc | input | 2 | Oscillator index of the write |
| tbl_wr_bias | input | 2 | Bias index of the write |
| tbl_wr_score | input | 64 | Score value written |
| start | input | 1 | Launch a search (ignored while one runs) |
| done | output | 1 | Search finished, results valid |
| pass | output | 1 | Best total meets the entropy floor |
| bias_word | output | 6 | Packed winning biases, zero when not passing |
| cell_score | output | 192 | Winning per-oscillator scores, zero when not passing |
| best_total | output | 66 | Winning summed score |
| ctl_words | output | 24 | Four 6-bit oscillator control words |

## Verification
Two functions can land in the same cycle: a table write coinciding with the accepted start, and a write or a second start arriving while the walk is running. The bench provokes the first by driving the write and the start on one edge. It checks that the winner reflects the new score. It provokes the second by writing a dominant score and re-pulsing start in mid-search. It then judges that the finishing cycle, the result, and a follow-up search without rewrite all match a model that dropped both.

// File: rtl/bas_pkg.sv
package bas_pkg;
   localparam int unsigned BAS_DEF_OSC     = 3;
   localparam int unsigned BAS_DEF_BIAS    = 4;
   localparam int unsigned BAS_DEF_SCORE_W = 64;
   localparam logic [63:0] BAS_DEF_FLOOR   = 64'd150000000;
endpackage

// File: rtl/bas_table.sv
module bas_table #(
   parameter int unsigned N_OSC   = 3,
   parameter int unsigned N_BIAS  = 4,
   parameter int unsigned SCORE_W = 64,
   parameter int unsigned OSC_W   = 2,
   parameter int unsigned BIAS_W  = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               lock,
   input  logic                               wr_en,
   input  logic [OSC_W-1:0]                   wr_osc,
   input  logic [BIAS_W-1:0]                  wr_bias,
   input  logic [SCORE_W-1:0]                 wr_data,
   output logic [N_OSC*N_BIAS*SCORE_W-1:0]    cells_flat
);
   localparam int unsigned CELLS = N_OSC * N_BIAS;

   logic [CELLS-1:0][SCORE_W-1:0] mem;

   for (genvar o = 0; o < N_OSC; o++) begin : g_osc
      for (genvar b = 0; b < N_BIAS; b++) begin : g_bias
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[o*N_BIAS + b] <= '0;
            end else if (wr_en && !lock &&
                         wr_osc == OSC_W'(o) && wr_bias == BIAS_W'(b)) begin
               mem[o*N_BIAS + b] <= wr_data;
            end
         end
      end
   end

   assign cells_flat = mem;

   AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(mem)); // R8
endmodule

// File: rtl/bas_walker.sv
module bas_walker #(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             accept,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = '1;

   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         idx  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         done <= 1'b0;
         idx  <= '0;
      end else if (busy) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R7
   AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == LAST) |=> (done && !busy)); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && idx != LAST) |=> (busy && idx == $past(idx) + IDX_W'(1))); // R7
endmodule

// File: rtl/bas_best.sv
module bas_best #(
   parameter int unsigned N_OSC   = 3,
   parameter int unsigned N_BIAS  = 4,
   parameter int unsigned SCORE_W = 64,
   parameter int unsigned BIAS_W  = 2,
   parameter int unsigned SUM_W   = 66,
   parameter int unsigned IDX_W   = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clear,
   input  logic                              eval,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [N_OSC*N_BIAS*SCORE_W-1:0]   cells_flat,
   output logic [SUM_W-1:0]                  best_total,
   output logic [N_OSC*BIAS_W-1:0]           best_bset,
   output logic [N_OSC*SCORE_W-1:0]          best_cells
);
   localparam int unsigned CELLS  = N_OSC * N_BIAS;
   localparam int unsigned CIDX_W = $clog2(CELLS);

   function automatic logic [N_OSC*BIAS_W-1:0] default_bset();
      logic [N_OSC*BIAS_W-1:0] v;
      v = '0;
      for (int o = 0; o < N_OSC; o++) v[o*BIAS_W +: BIAS_W] = BIAS_W'(o);
      return v;
   endfunction
   localparam logic [N_OSC*BIAS_W-1:0] DEF_BSET = default_bset();

   logic [CELLS-1:0][SCORE_W-1:0] cv;
   logic [N_OSC-1:0][BIAS_W-1:0]  cand_b;
   logic [N_OSC-1:0][SCORE_W-1:0] cand_s;
   logic [N_OSC*BIAS_W-1:0]       cand_bset;
   logic [SUM_W-1:0]              cand_sum;
   logic                          cand_ok;
   logic                          take;
   logic                          best_ok;
   logic [SUM_W-1:0]              best_resum;

   assign cv = cells_flat;

   always_comb begin
      cand_sum  = '0;
      cand_ok   = 1'b1;
      cand_bset = '0;
      for (int o = 0; o < N_OSC; o++) begin
         cand_b[o] = idx[(N_OSC-1-o)*BIAS_W +: BIAS_W];
         cand_bset[o*BIAS_W +: BIAS_W] = cand_b[o];
         cand_s[o] = cv[CIDX_W'(o*N_BIAS) + CIDX_W'(cand_b[o])];
         cand_sum  = cand_sum + SUM_W'(cand_s[o]);
      end
      for (int i = 0; i < N_OSC; i++)
         for (int j = i + 1; j < N_OSC; j++)
            if (cand_b[i] == cand_b[j]) cand_ok = 1'b0;
   end

   assign take = eval && cand_ok && (cand_sum > best_total);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_total <= '0;
         best_bset  <= DEF_BSET;
         best_cells <= '0;
      end else if (clear) begin
         best_total <= '0;
         best_bset  <= DEF_BSET;
         best_cells <= '0;
      end else if (take) begin
         best_total <= cand_sum;
         best_bset  <= cand_bset;
         best_cells <= cand_s;
      end
   end

   always_comb begin
      best_ok    = 1'b1;
      best_resum = '0;
      for (int i = 0; i < N_OSC; i++) begin
         best_resum = best_resum + SUM_W'(best_cells[i*SCORE_W +: SCORE_W]);
         for (int j = i + 1; j < N_OSC; j++)
            if (best_bset[i*BIAS_W +: BIAS_W] == best_bset[j*BIAS_W +: BIAS_W])
               best_ok = 1'b0;
      end
   end

   AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !clear) |=> best_total >= $past(best_total)); // R2
   AST_WINNER_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      best_ok); // R1
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      best_total == best_resum); // R9
endmodule

// File: rtl/bias_assign_search.sv
module bias_assign_search
   import bas_pkg::*;
#(
   parameter int unsigned N_OSC       = BAS_DEF_OSC,
   parameter int unsigned N_BIAS      = BAS_DEF_BIAS,
   parameter int unsigned SCORE_W     = BAS_DEF_SCORE_W,
   parameter logic [63:0] PASS_LEVEL  = BAS_DEF_FLOOR,
   parameter int unsigned OSC_W       = $clog2(N_OSC),
   parameter int unsigned BIAS_W      = $clog2(N_BIAS),
   parameter int unsigned SUM_W       = SCORE_W + $clog2(N_OSC),
   parameter int unsigned CTL_W       = N_OSC + BIAS_W + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tbl_wr_en,
   input  logic [OSC_W-1:0]             tbl_wr_osc,
   input  logic [BIAS_W-1:0]            tbl_wr_bias,
   input  logic [SCORE_W-1:0]           tbl_wr_score,
   input  logic                         start,
   output logic                         done,
   output logic                         pass,
   output logic [N_OSC*BIAS_W-1:0]      bias_word,
   output logic [N_OSC*SCORE_W-1:0]     cell_score,
   output logic [SUM_W-1:0]             best_total,
   output logic [(N_OSC+1)*CTL_W-1:0]   ctl_words
);
   localparam int unsigned IDX_W = N_OSC * BIAS_W;
   localparam logic [SUM_W-1:0] PASS_SUM = SUM_W'(PASS_LEVEL);

   if (N_OSC < 2)                 begin : g_bad_osc   $error("N_OSC must be at least 2");        end
   if (N_BIAS != (1 << BIAS_W))   begin : g_bad_bias  $error("N_BIAS must be a power of two");   end
   if (N_OSC > N_BIAS)            begin : g_bad_ratio $error("N_OSC must not exceed N_BIAS");    end
   if (SUM_W < 64)                begin : g_bad_sum   $error("sum too narrow for pass level");   end

   logic                              busy;
   logic                              accept;
   logic [IDX_W-1:0]                  idx;
   logic [N_OSC*N_BIAS*SCORE_W-1:0]   cells_flat;
   logic [N_OSC*BIAS_W-1:0]           best_bset;
   logic [N_OSC*SCORE_W-1:0]          best_cells;

   bas_table #(
      .N_OSC(N_OSC), .N_BIAS(N_BIAS), .SCORE_W(SCORE_W),
      .OSC_W(OSC_W), .BIAS_W(BIAS_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .lock(busy),
      .wr_en(tbl_wr_en), .wr_osc(tbl_wr_osc), .wr_bias(tbl_wr_bias),
      .wr_data(tbl_wr_score), .cells_flat(cells_flat)
   );

   bas_walker #(.IDX_W(IDX_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .accept(accept), .idx(idx)
   );

   bas_best #(
      .N_OSC(N_OSC), .N_BIAS(N_BIAS), .SCORE_W(SCORE_W),
      .BIAS_W(BIAS_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
   ) u_best (
      .clk(clk), .rst_n(rst_n), .clear(accept), .eval(busy), .idx(idx),
      .cells_flat(cells_flat), .best_total(best_total),
      .best_bset(best_bset), .best_cells(best_cells)
   );

   assign pass       = done && (best_total >= PASS_SUM);
   assign bias_word  = pass ? best_bset  : '0;
   assign cell_score = pass ? best_cells : '0;

   for (genvar n = 0; n < N_OSC; n++) begin : g_ctl
      localparam logic [N_OSC-1:0] SEL = N_OSC'(1) << n;
      assign ctl_words[n*CTL_W +: CTL_W] = {1'b1, best_bset[n*BIAS_W +: BIAS_W], SEL};
   end
   assign ctl_words[N_OSC*CTL_W +: CTL_W] = {1'b1, {BIAS_W{1'b0}}, {N_OSC{1'b1}}};

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(best_total) && $stable(best_bset))); // R7
endmodule

// File: tb/bias_assign_search_bench.sv
module bias_assign_search_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tbl_wr_en = 1'b0;
   logic [1:0]   tbl_wr_osc = '0;
   logic [1:0]   tbl_wr_bias = '0;
   logic [63:0]  tbl_wr_score = '0;
   logic         start = 1'b0;
   logic         done, pass;
   logic [5:0]   bias_word;
   logic [191:0] cell_score;
   logic [65:0]  best_total;
   logic [23:0]  ctl_words;

   always #2 clk = ~clk;

   bias_assign_search u_bias_assign_search (
      .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_osc(tbl_wr_osc),
      .tbl_wr_bias(tbl_wr_bias), .tbl_wr_score(tbl_wr_score), .start(start),
      .done(done), .pass(pass), .bias_word(bias_word), .cell_score(cell_score),
      .best_total(best_total), .ctl_words(ctl_words)
   );

   typedef struct {
      logic [5:0]   bw;
      logic [191:0] cs;
      logic [65:0]  tot;
      logic         ps;
      logic [23:0]  ctl;
      int           due;
   } exp_t;

   exp_t        q[$];
   logic [63:0] tm [3][4];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   logic        done_q = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endtask

   // Reference built from R1..R6 and R9
   task automatic model(output exp_t e);
      logic [65:0] best, t;
      logic [5:0]  bs;
      logic [191:0] cw;
      best = '0;
      bs   = 6'b10_01_00;
      cw   = '0;
      for (int b0 = 0; b0 < 4; b0++)
         for (int b1 = 0; b1 < 4; b1++)
            for (int b2 = 0; b2 < 4; b2++) begin
               if (b0 == b1 || b0 == b2 || b1 == b2) continue;
               t = 66'(tm[0][b0]) + 66'(tm[1][b1]) + 66'(tm[2][b2]);
               if (t > best) begin
                  best = t;
                  bs   = {2'(b2), 2'(b1), 2'(b0)};
                  cw   = {tm[2][b2], tm[1][b1], tm[0][b0]};
               end
            end
      e.tot = best;
      e.ps  = (best >= 66'd150000000);
      e.bw  = e.ps ? bs : 6'd0;
      e.cs  = e.ps ? cw : 192'd0;
      for (int n = 0; n < 3; n++)
         e.ctl[n*6 +: 6] = {1'b1, bs[n*2 +: 2], 3'(1 << n)};
      e.ctl[23:18] = 6'b1_00_111;
      e.due = 0;
   endtask

   task automatic put(input int o, input int b, input logic [63:0] v, input bit track);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_osc = 2'(o); tbl_wr_bias = 2'(b); tbl_wr_score = v;
      if (track) tm[o][b] = v;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   task automatic fill(input logic [63:0] v);
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 4; b++) put(o, b, v, 1'b1);
   endtask

   task automatic kick(input bit with_wr, input int o, input int b, input logic [63:0] v);
      exp_t e;
      @(negedge clk);
      start = 1'b1;
      if (with_wr) begin
         tbl_wr_en = 1'b1; tbl_wr_osc = 2'(o); tbl_wr_bias = 2'(b); tbl_wr_score = v;
         tm[o][b] = v;
      end
      model(e);
      e.due = cyc + 65;
      q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      tbl_wr_en = 1'b0;
   endtask

   task automatic settle();
      while (q.size() != 0) @(negedge clk);
   endtask

   // Monitor: compares each rising done against the oldest expected item
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (done && !done_q) begin
            if (q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R7 unexpected done got 1 exp 0");
            end else begin
               e = q.pop_front();
               chk("R7 done latency", 256'(cyc), 256'(e.due));
               chk("R1/R2 bias_word", 256'(bias_word), 256'(e.bw));
               chk("R4 pass", 256'(pass), 256'(e.ps));
               chk("R4/R9 cell_score", 256'(cell_score), 256'(e.cs));
               chk("R9 best_total", 256'(best_total), 256'(e.tot));
               chk("R5/R6 ctl_words", 256'(ctl_words), 256'(e.ctl));
            end
         end
         done_q = done;
      end
   end

   initial begin
      wait (cyc == 20000);
      checks++; errors++;
      $display("FAIL watchdog got %0d exp below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      exp_t r;
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 4; b++) tm[o][b] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      model(r);
      chk("R10 reset done", 256'(done), 256'(0));
      chk("R10 reset pass", 256'(pass), 256'(0));
      chk("R10 reset best_total", 256'(best_total), 256'(0));
      chk("R10 reset bias_word", 256'(bias_word), 256'(0));
      chk("R10/R5 reset ctl_words", 256'(ctl_words), 256'(r.ctl));

      // R3: empty table keeps the default assignment
      kick(1'b0, 0, 0, '0); settle();

      // R1/R2: spread of distinct scores
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 4; b++)
            put(o, b, 64'(40000000 + ((o * 7 + b * 13) % 11) * 5000000), 1'b1);
      kick(1'b0, 0, 0, '0); settle();

      // R1: every oscillator prefers bias 3
      fill(64'd1000000);
      put(0, 3, 64'd900000000, 1'b1);
      put(1, 3, 64'd800000000, 1'b1);
      put(2, 3, 64'd700000000, 1'b1);
      kick(1'b0, 0, 0, '0); settle();

      // R2: tie between (1,0,2) and (1,0,3), earlier one kept
      fill('0);
      put(0, 1, 64'd100000000, 1'b1);
      put(1, 0, 64'd100000000, 1'b1);
      put(2, 2, 64'd100000000, 1'b1);
      put(2, 3, 64'd100000000, 1'b1);
      kick(1'b0, 0, 0, '0); settle();
      chk("R2 tie winner", 256'(bias_word), 256'(6'b10_00_01));

      // R4: total exactly at the floor, then one below
      fill('0);
      put(0, 0, 64'd50000000, 1'b1);
      put(1, 1, 64'd50000000, 1'b1);
      put(2, 2, 64'd50000000, 1'b1);
      kick(1'b0, 0, 0, '0); settle();
      chk("R4 pass at floor", 256'(pass), 256'(1));
      put(2, 2, 64'd49999999, 1'b1);
      kick(1'b0, 0, 0, '0); settle();
      chk("R4 fail below floor", 256'(pass), 256'(0));
      chk("R4 zeroed bias_word", 256'(bias_word), 256'(0));

      // R9: all scores at maximum
      fill('1);
      kick(1'b0, 0, 0, '0); settle();
      chk("R9 max total", 256'(best_total), 256'(66'h2_FFFF_FFFF_FFFF_FFFD));

      // R8: write while running is dropped; rerun shows old table
      fill(64'd60000000);
      kick(1'b0, 0, 0, '0);
      repeat (5) @(negedge clk);
      put(1, 2, 64'd5000000000, 1'b0);
      settle();
      kick(1'b0, 0, 0, '0); settle();

      // R8: write in the same cycle as start is used
      kick(1'b1, 2, 0, 64'd2000000000); settle();
      chk("R8 same-cycle write winner", 256'(bias_word[5:4]), 256'(0));

      // R7: second start in mid-search is ignored
      kick(1'b0, 0, 0, '0);
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      settle();
      repeat (4) @(negedge clk);
      chk("R7 done holds", 256'(done), 256'(1));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule